// File: doc/BRIEF.md
# VPW Frame Sequence Validator

This block sits behind the symbol decoder of a variable-pulse-width serial bus receiver. Each decoded symbol arrives as a one-cycle strobe: start-of-frame, data bit, end-of-data, end-of-frame, normalization bit or break. The validator follows where the frame stands. The positions are: idle, message data, the gap after the first end-of-data, response data, and waiting for end-of-frame. It also counts data bits and bytes. From these it decides whether the symbol order is illegal or the frame fails its CRC. The CRC verdict comes from an external engine through `crc_ok_i`, and the block tells that engine when to restart through `crc_init_o`.

An error is reported with a one-cycle pulse. The block then holds the receiver disabled and asks for the queued transmit to be dropped. It stays silent until the next end-of-frame, so a frame produces at most one report. A sleep/filter mode suppresses error reporting while the node is not transmitting. A received break also disables the receiver and drops the transmit, but raises no error.

Top module: `vpw_seq_check`

## Requirements
- R1: After reset all outputs are 0.
- R2: A data bit while idle (a start-of-frame is expected) gives a pulse on `ifd_o`.
- R3: In message or response data, two symbols give an `ifd_o` pulse: a start-of-frame, or an end-of-data that arrives while the bit count is not a multiple of 8.
- R4: After the first end-of-data and before end-of-frame, a start-of-frame or a data bit gives an `ifd_o` pulse. A normalization bit starts the response string instead.
- R5: With `lim_off_i` = 0, data bit number 97 of a frame (12 bytes plus one bit) gives an `ifd_o` pulse. With `lim_off_i` = 1, no length error is raised.
- R6: After the second end-of-data of a frame, any symbol other than end-of-frame (start-of-frame, data bit, normalization bit, end-of-data) gives an `ifd_o` pulse.
- R7: An end-of-data on a whole byte boundary ends a string. If `crc_ok_i` = 0 in that same cycle, `crc_err_o` pulses. This applies after the message and after the response. `crc_init_o` pulses for a start-of-frame while idle and for a normalization bit in the gap.
- R8: Each error pulse comes with a `tx_cancel_o` pulse and sets `rx_dis_o`. While `rx_dis_o` = 1, no further error pulse is raised.
- R9: While `quiet_i` = 1 and `tx_act_i` = 0, no error pulse is raised and `rx_dis_o` is not set by errors.
- R10: End-of-frame clears `rx_dis_o`, the bit and byte counts, and the end-of-data position. The block then expects a start-of-frame.
- R11: `byte_rdy_o` pulses for every 8th data bit in message or response data, and never while `rx_dis_o` = 1.
- R12: A break gives a `tx_cancel_o` pulse and sets `rx_dis_o` until end-of-frame, without any error pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame strobe |
| bit_i | input | 1 | Data bit strobe (logic 0 or 1) |
| eod_i | input | 1 | End-of-data strobe |
| eof_i | input | 1 | End-of-frame strobe |
| nb_i | input | 1 | Normalization bit strobe |
| brk_i | input | 1 | Break strobe |
| crc_ok_i | input | 1 | CRC residue valid, sampled with `eod_i` |
| quiet_i | input | 1 | Sleep/filter mode |
| tx_act_i | input | 1 | Node currently transmitting |
| lim_off_i | input | 1 | 1 disables the 12-byte frame limit |
| ifd_o | output | 1 | Invalid-frame pulse |
| crc_err_o | output | 1 | CRC-error pulse |
| rx_dis_o | output | 1 | Receiver disabled until end-of-frame |
| tx_cancel_o | output | 1 | Drop queued transmit pulse |
| byte_rdy_o | output | 1 | Byte complete pulse |
| crc_init_o | output | 1 | Restart CRC accumulation pulse |

## Verification
Every output is a register that is loaded on the edge sampling the strobe. So `ifd_o`, `crc_err_o`, `tx_cancel_o`, `byte_rdy_o` and `crc_init_o` are high for exactly the cycle after a symbol, and `rx_dis_o` changes in that same cycle. The bench drives each strobe on a falling edge, removes it on the next falling edge, and reads the outputs at that moment. Every check therefore sees the response to one symbol only, one edge after it. The length sweep steps bit by bit from 1 to 100 in both limit settings and compares against counts computed arithmetically.

// File: rtl/vpw_seq_pkg.sv
package vpw_seq_pkg;
  typedef enum logic [2:0] {
    FS_IDLE,
    FS_MSG,
    FS_GAP,
    FS_RSP,
    FS_END
  } frame_st_e;
endpackage

// File: rtl/vpw_bit_count.sv
module vpw_bit_count #(
  parameter int BYTE_BITS = 8,
  parameter int MAX_BYTES = 12,
  localparam int BIW = $clog2(BYTE_BITS),
  localparam int BYW = $clog2(MAX_BYTES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic bit_i,
  output logic byte_done_o,
  output logic mid_byte_o,
  output logic at_limit_o
);
  localparam logic [BIW-1:0] LAST_BIT = BIW'(BYTE_BITS - 1);
  localparam logic [BYW-1:0] LIMIT    = BYW'(MAX_BYTES);

  logic [BIW-1:0] bit_q;
  logic [BYW-1:0] byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (clr_i) begin
      bit_q  <= '0;
      byte_q <= '0;
    end else if (bit_i) begin
      bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
      if (bit_q == LAST_BIT && byte_q != LIMIT) byte_q <= byte_q + 1'b1;
    end
  end

  assign byte_done_o = bit_i && (bit_q == LAST_BIT);
  assign mid_byte_o  = (bit_q != '0);
  assign at_limit_o  = (byte_q == LIMIT) && (bit_q == '0);
endmodule

// File: rtl/vpw_order_fsm.sv
module vpw_order_fsm
  import vpw_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic bit_i,
  input  logic eod_i,
  input  logic eof_i,
  input  logic nb_i,
  input  logic crc_ok_i,
  input  logic lim_off_i,
  input  logic mid_byte_i,
  input  logic at_limit_i,
  output logic in_data_o,
  output logic ifd_raw_o,
  output logic crc_raw_o,
  output logic crc_init_o
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d       = st_q;
    ifd_raw_o  = 1'b0;
    crc_raw_o  = 1'b0;
    crc_init_o = 1'b0;
    unique case (st_q)
      FS_IDLE: begin
        if (sof_i) begin
          st_d       = FS_MSG;
          crc_init_o = 1'b1;
        end else if (bit_i) ifd_raw_o = 1'b1;
      end
      FS_MSG, FS_RSP: begin
        if (sof_i) ifd_raw_o = 1'b1;
        else if (bit_i && at_limit_i && !lim_off_i) ifd_raw_o = 1'b1;
        else if (eod_i) begin
          if (mid_byte_i) ifd_raw_o = 1'b1;
          else begin
            crc_raw_o = !crc_ok_i;
            st_d      = (st_q == FS_MSG) ? FS_GAP : FS_END;
          end
        end
      end
      FS_GAP: begin
        if (sof_i || bit_i) ifd_raw_o = 1'b1;
        else if (nb_i) begin
          st_d       = FS_RSP;
          crc_init_o = 1'b1;
        end
      end
      FS_END: begin
        if (sof_i || bit_i || nb_i || eod_i) ifd_raw_o = 1'b1;
      end
      default: st_d = FS_IDLE;
    endcase
    if (eof_i) begin
      st_d       = FS_IDLE;
      ifd_raw_o  = 1'b0;
      crc_raw_o  = 1'b0;
      crc_init_o = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= FS_IDLE;
    else         st_q <= st_d;
  end

  assign in_data_o = (st_q == FS_MSG) || (st_q == FS_RSP);
endmodule

// File: rtl/vpw_seq_check.sv
module vpw_seq_check #(
  parameter int BYTE_BITS = 8,
  parameter int MAX_BYTES = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sof_i,
  input  logic bit_i,
  input  logic eod_i,
  input  logic eof_i,
  input  logic nb_i,
  input  logic brk_i,
  input  logic crc_ok_i,
  input  logic quiet_i,
  input  logic tx_act_i,
  input  logic lim_off_i,
  output logic ifd_o,
  output logic crc_err_o,
  output logic rx_dis_o,
  output logic tx_cancel_o,
  output logic byte_rdy_o,
  output logic crc_init_o
);
  logic in_data, data_bit, byte_done, mid_byte, at_limit;
  logic ifd_raw, crc_raw, crc_init;
  logic mute_q, err_ok, fire_ifd, fire_crc;

  assign data_bit = bit_i && in_data;

  vpw_bit_count #(.BYTE_BITS(BYTE_BITS), .MAX_BYTES(MAX_BYTES)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (eof_i),
    .bit_i       (data_bit),
    .byte_done_o (byte_done),
    .mid_byte_o  (mid_byte),
    .at_limit_o  (at_limit)
  );

  vpw_order_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sof_i      (sof_i),
    .bit_i      (bit_i),
    .eod_i      (eod_i),
    .eof_i      (eof_i),
    .nb_i       (nb_i),
    .crc_ok_i   (crc_ok_i),
    .lim_off_i  (lim_off_i),
    .mid_byte_i (mid_byte),
    .at_limit_i (at_limit),
    .in_data_o  (in_data),
    .ifd_raw_o  (ifd_raw),
    .crc_raw_o  (crc_raw),
    .crc_init_o (crc_init)
  );

  // errors muted after first report and in quiet mode unless transmitting
  assign err_ok   = !mute_q && !(quiet_i && !tx_act_i);
  assign fire_ifd = ifd_raw && err_ok;
  assign fire_crc = crc_raw && err_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mute_q      <= 1'b0;
      ifd_o       <= 1'b0;
      crc_err_o   <= 1'b0;
      tx_cancel_o <= 1'b0;
      byte_rdy_o  <= 1'b0;
      crc_init_o  <= 1'b0;
    end else begin
      mute_q      <= eof_i ? 1'b0 : (mute_q || fire_ifd || fire_crc || brk_i);
      ifd_o       <= fire_ifd;
      crc_err_o   <= fire_crc;
      tx_cancel_o <= !eof_i && (fire_ifd || fire_crc || brk_i);
      byte_rdy_o  <= byte_done && !mute_q;
      crc_init_o  <= crc_init;
    end
  end

  assign rx_dis_o = mute_q;
endmodule

// File: rtl/vpw_seq_chk.sv
module vpw_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic eof_i,
  input logic quiet_i,
  input logic tx_act_i,
  input logic ifd_o,
  input logic crc_err_o,
  input logic rx_dis_o,
  input logic tx_cancel_o,
  input logic byte_rdy_o
);
  AST_ERR_CANCELS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifd_o || crc_err_o) |-> (tx_cancel_o && rx_dis_o)); // R8
  AST_ONCE_PER_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ifd_o || crc_err_o) |-> !$past(rx_dis_o)); // R8
  AST_QUIET_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(quiet_i && !tx_act_i) |-> !(ifd_o || crc_err_o)); // R9
  AST_EOF_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(eof_i) |-> !rx_dis_o); // R10
  AST_NO_BYTE_MUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_rdy_o |-> !$past(rx_dis_o)); // R11
endmodule

bind vpw_seq_check vpw_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .eof_i       (eof_i),
  .quiet_i     (quiet_i),
  .tx_act_i    (tx_act_i),
  .ifd_o       (ifd_o),
  .crc_err_o   (crc_err_o),
  .rx_dis_o    (rx_dis_o),
  .tx_cancel_o (tx_cancel_o),
  .byte_rdy_o  (byte_rdy_o)
);

// File: tb/sim_vpw_seq_check.sv
module sim_vpw_seq_check;
  localparam int K_SOF = 0, K_BIT = 1, K_EOD = 2, K_EOF = 3, K_NB = 4, K_BRK = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sof_i = 0, bit_i = 0, eod_i = 0, eof_i = 0, nb_i = 0, brk_i = 0;
  logic crc_ok_i = 1, quiet_i = 0, tx_act_i = 0, lim_off_i = 0;
  logic ifd_o, crc_err_o, rx_dis_o, tx_cancel_o, byte_rdy_o, crc_init_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  vpw_seq_check u0 (.clk_i(clk), .rst_ni(rst_ni), .sof_i(sof_i), .bit_i(bit_i),
    .eod_i(eod_i), .eof_i(eof_i), .nb_i(nb_i), .brk_i(brk_i), .crc_ok_i(crc_ok_i),
    .quiet_i(quiet_i), .tx_act_i(tx_act_i), .lim_off_i(lim_off_i), .ifd_o(ifd_o),
    .crc_err_o(crc_err_o), .rx_dis_o(rx_dis_o), .tx_cancel_o(tx_cancel_o),
    .byte_rdy_o(byte_rdy_o), .crc_init_o(crc_init_o));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // strobe for one cycle; on return outputs show the response
  task automatic send(input int k);
    @(negedge clk);
    case (k)
      K_SOF: sof_i = 1;
      K_BIT: bit_i = 1;
      K_EOD: eod_i = 1;
      K_EOF: eof_i = 1;
      K_NB:  nb_i  = 1;
      default: brk_i = 1;
    endcase
    @(negedge clk);
    {sof_i, bit_i, eod_i, eof_i, nb_i, brk_i} = '0;
  endtask

  task automatic send_byte();
    for (int i = 0; i < 8; i++) send(K_BIT);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1", "ifd", ifd_o, 0);       chk("R1", "crc", crc_err_o, 0);
    chk("R1", "dis", rx_dis_o, 0);    chk("R1", "cancel", tx_cancel_o, 0);
    chk("R1", "byte", byte_rdy_o, 0); chk("R1", "init", crc_init_o, 0);

    // R2 bit while idle
    send(K_BIT);
    chk("R2", "ifd", ifd_o, 1);
    chk("R8", "cancel", tx_cancel_o, 1);
    chk("R8", "dis", rx_dis_o, 1);
    send(K_BIT);
    chk("R8", "ifd muted", ifd_o, 0);
    send(K_EOF);
    chk("R10", "dis clear", rx_dis_o, 0);

    // R3 sof in data, eod mid byte
    send(K_SOF);
    chk("R7", "init on sof", crc_init_o, 1);
    repeat (3) send(K_BIT);
    send(K_SOF);
    chk("R3", "sof in data", ifd_o, 1);
    send(K_EOF);
    send(K_SOF);
    repeat (5) send(K_BIT);
    send(K_EOD);
    chk("R3", "eod mid byte", ifd_o, 1);
    send(K_EOF);

    // R7 crc after message and after response
    send(K_SOF); send_byte(); send_byte();
    crc_ok_i = 0;
    send(K_EOD);
    chk("R7", "crc msg", crc_err_o, 1);
    chk("R7", "no ifd", ifd_o, 0);
    crc_ok_i = 1;
    send(K_EOF);
    send(K_SOF); send_byte();
    send(K_EOD);
    chk("R7", "crc good", crc_err_o, 0);
    send(K_NB);
    chk("R7", "init on nb", crc_init_o, 1);
    send_byte();
    crc_ok_i = 0;
    send(K_EOD);
    chk("R7", "crc rsp", crc_err_o, 1);
    crc_ok_i = 1;
    send(K_EOF);

    // R4 gap
    send(K_SOF); send_byte(); send(K_EOD);
    send(K_SOF);
    chk("R4", "sof in gap", ifd_o, 1);
    send(K_EOF);
    send(K_SOF); send_byte(); send(K_EOD);
    send(K_BIT);
    chk("R4", "bit in gap", ifd_o, 1);
    send(K_EOF);

    // R6 second eod
    send(K_SOF); send_byte(); send(K_EOD); send(K_NB); send_byte(); send(K_EOD);
    chk("R6", "clean", ifd_o, 0);
    send(K_NB);
    chk("R6", "nb after eod2", ifd_o, 1);
    send(K_EOF);
    send(K_SOF); send_byte(); send(K_EOD); send(K_NB); send_byte(); send(K_EOD);
    send(K_EOF);
    chk("R6", "eof after eod2", ifd_o, 0);
    chk("R10", "dis", rx_dis_o, 0);

    // R9 quiet mode
    quiet_i = 1;
    send(K_BIT);
    chk("R9", "ifd quiet", ifd_o, 0);
    chk("R9", "dis quiet", rx_dis_o, 0);
    tx_act_i = 1;
    send(K_BIT);
    chk("R9", "ifd quiet tx", ifd_o, 1);
    send(K_EOF);
    quiet_i = 0; tx_act_i = 0;

    // R12 break
    send(K_SOF); send_byte();
    send(K_BRK);
    chk("R12", "cancel", tx_cancel_o, 1);
    chk("R12", "dis", rx_dis_o, 1);
    chk("R12", "no ifd", ifd_o, 0);
    send(K_SOF);
    chk("R12", "muted sof", ifd_o, 0);
    send_byte();
    chk("R11", "no byte muted", byte_rdy_o, 0);
    send(K_EOF);
    chk("R10", "dis after brk", rx_dis_o, 0);

    // R5 / R11 length sweep
    for (int lim = 0; lim < 2; lim++) begin
      lim_off_i = lim[0];
      send(K_SOF);
      for (int i = 1; i <= 100; i++) begin
        send(K_BIT);
        chk("R5", $sformatf("ifd lim%0d bit%0d", lim, i), ifd_o, (lim == 0 && i == 97));
        chk("R11", $sformatf("byte lim%0d bit%0d", lim, i), byte_rdy_o,
            (i % 8 == 0) && !(lim == 0 && i > 97));
      end
      send(K_EOF);
    end
    lim_off_i = 0;
    // R10: counts cleared, fresh frame byte ready at bit 8
    send(K_SOF);
    for (int i = 1; i <= 8; i++) begin
      send(K_BIT);
      chk("R10", $sformatf("byte after eof bit%0d", i), byte_rdy_o, i == 8);
    end
    send(K_EOF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule